// File: doc/BRIEF.md
# Flash Embedded Operation Sequencer

This unit runs one embedded program or erase operation on a byte-wide flash array model. It starts when it sees a start pulse together with an operation kind. A single cycle counter stands in for the physical program and erase timing. While an operation is in flight the unit owns the array port, and every host read returns a status byte in place of array data. The status byte carries three indicators. A data-polling bit is the inverse of the target's top bit. A toggle bit flips on each read strobe. A timeout bit rises when the operation overruns the limit that the host sets.

A program writes the old byte ANDed with the requested byte, so a program can only clear bits. The unit then waits for the minimum program time and compares the array byte with the target. If the array byte can never match, because the host asked for a 0-to-1 change, the counter runs out. The unit then stays in the timeout state until a reset command arrives. An erase first writes zeros across its range, then writes FFh across the same range. It works one byte per cycle, over either one sector or the whole array.

Top module: `flash_op_sequencer`

## Requirements
- R1: After synchronous active-low reset, `busy`, `done` and `arr_we` are 0 and the unit is idle.
- R2: `op_kind` encodes 0 = program, 1 = sector erase, 2 = chip erase. A start pulse with code 3, or any start pulse while busy, is ignored.
- R3: A program drives `arr_we` for exactly one cycle, at the latched address, with data equal to the old array byte AND the target byte.
- R4: A program completes once at least `PROG_CYCLES` counted cycles have passed and the array byte equals the target. `done` is then high for one cycle, and `busy` falls in that same cycle.
- R5: While busy, `rd_data[7]` is the inverse of the target's bit 7 (the erase target is FFh), and `rd_data[4:0]` is 0.
- R6: While busy, `rd_data[6]` is 0 at the start and inverts after every cycle in which `rd_strobe` is high.
- R7: If the counter reaches `time_limit` before completion, `rd_data[5]` becomes 1. `busy` then stays high and `done` is never raised.
- R8: `reset_cmd` returns the unit to idle only from the timeout state. It is ignored while an operation is still running.
- R9: A chip erase writes 00h and then FFh to every address. A sector erase does the same only for the sector that the top `SECT_W` bits of `op_addr` select. Completion is signalled as soon as the last FFh write is done.
- R10: No array write sets a bit that the array currently holds at 0, except an FFh erase fill.
- R11: While idle, `arr_addr` follows `host_addr` and `rd_data` returns the array byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | One-cycle start pulse |
| op_kind | input | 2 | Operation code (see R2) |
| op_addr | input | ADDR_W | Program address or sector selector |
| op_data | input | 8 | Program target byte |
| time_limit | input | TMR_W | Counter value that triggers timeout |
| rd_strobe | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host read address |
| reset_cmd | input | 1 | Return-to-read command |
| arr_rdata | input | 8 | Array byte at `arr_addr` |
| arr_addr | output | ADDR_W | Array address |
| arr_we | output | 1 | Array write enable |
| arr_wdata | output | 8 | Array write data |
| rd_data | output | 8 | Host read data or status byte |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first program sets a clean FFh byte to a pattern whose top bit is 0, and a second program uses a pattern whose top bit is 1. Together they tell apart a data-polling bit that follows the target from one that is a constant. A third program requests a 0-to-1 change on a byte that was already programmed. This separates a plain overwrite from the AND rule, and it drives the path to timeout and out of it. A sector erase, a chip erase with enough time, and a chip erase that is cut off by its limit are then checked by reading back addresses inside and outside the range. These show that the range selection and both sweep passes are correct. Read strobes and a reset command are issued while operations are still running, to exercise the toggle bit and the cases where input is ignored.

// File: rtl/flash_op_pkg.sv
// Package: shared operation codes and sequencer states.
// Assumes: 2-bit operation code on the host side.
package flash_op_pkg;
    typedef enum logic [1:0] {
        OPK_PROG = 2'd0,
        OPK_SECT = 2'd1,
        OPK_CHIP = 2'd2,
        OPK_NONE = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PWR   = 3'd1,
        ST_PWAIT = 3'd2,
        ST_ZERO  = 3'd3,
        ST_FILL  = 3'd4,
        ST_TMO   = 3'd5
    } seq_state_e;
endpackage

// File: rtl/flash_op_timer.sv
// Operation counter: cleared at start, advanced every running cycle.
// Reports minimum program time reached and time limit reached.
// Assumes: the limit input is held stable while an operation runs.
module flash_op_timer #(
    parameter int TMR_W       = 16,
    parameter int PROG_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [TMR_W-1:0] limit,
    output logic             lim_hit,
    output logic             min_hit
);
    localparam logic [TMR_W-1:0] MIN_C = TMR_W'(PROG_CYCLES);

    logic [TMR_W-1:0] cnt_q;

    // Count running cycles; restart on each accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    // Threshold compares used by the sequencer.
    always_comb begin
        lim_hit = (cnt_q >= limit);
        min_hit = (cnt_q >= MIN_C);
    end
endmodule

// File: rtl/flash_op_sweep.sv
// Address sweeper for erase passes: one address per step over a sector
// or the full array. Assumes SECT_W < ADDR_W.
module flash_op_sweep #(
    parameter int ADDR_W = 8,
    parameter int SECT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic              whole,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int LOW_W = ADDR_W - SECT_W;

    logic [ADDR_W-1:0] idx_q;

    // Walk the index; cleared at the start of each pass.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx_q <= '0;
        else if (clr)   idx_q <= '0;
        else if (step)  idx_q <= idx_q + 1'b1;
    end

    generate
        if (SECT_W > 0) begin : g_sect
            // Compose address from sector bits and in-sector index.
            always_comb begin
                addr = whole ? idx_q : {base[ADDR_W-1:LOW_W], idx_q[LOW_W-1:0]};
                last = whole ? (&idx_q) : (&idx_q[LOW_W-1:0]);
            end
        end else begin : g_flat
            // Without sectors every erase covers the whole array.
            always_comb begin
                addr = idx_q;
                last = &idx_q;
            end
        end
    endgenerate
endmodule

// File: rtl/flash_op_status.sv
// Read-path mux: array byte when idle, status byte when busy.
// Holds the toggle indicator. Assumes an 8-bit data bus.
module flash_op_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       busy,
    input  logic       rd_strobe,
    input  logic       tgt_msb,
    input  logic       timed_out,
    input  logic [7:0] arr_rdata,
    output logic [7:0] rd_data
);
    logic tog_q;

    // Toggle indicator: zeroed at start, inverted per busy read.
    always_ff @(posedge clk) begin
        if (!rst_n)                  tog_q <= 1'b0;
        else if (clr)                tog_q <= 1'b0;
        else if (busy && rd_strobe)  tog_q <= ~tog_q;
    end

    // Select status byte or array byte for the host.
    always_comb begin
        if (busy) rd_data = {~tgt_msb, tog_q, timed_out, 5'b00000};
        else      rd_data = arr_rdata;
    end
endmodule

// File: rtl/flash_op_sequencer.sv
// Top: embedded program/erase sequencer. Accepts an operation when idle,
// owns the array port while busy, programs with an AND so bits only clear,
// erases by a zero pass then an FFh pass, and holds on timeout until a
// reset command. Assumes time_limit is stable during an operation.
module flash_op_sequencer
    import flash_op_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SECT_W      = 2,
    parameter int TMR_W       = 16,
    parameter int PROG_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic [TMR_W-1:0]  time_limit,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              reset_cmd,
    input  logic [7:0]        arr_rdata,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_we,
    output logic [7:0]        arr_wdata,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              done
);
    seq_state_e        state_q, state_d;
    logic [7:0]        tgt_q;
    logic [ADDR_W-1:0] paddr_q;
    logic              whole_q;
    logic              done_q;
    logic              accept, running, erasing;
    logic              lim_hit, min_hit;
    logic              sw_last, sw_clr;
    logic [ADDR_W-1:0] sw_addr;
    op_kind_e          kind;

    // Decode the start request.
    always_comb begin
        kind    = op_kind_e'(op_kind);
        accept  = (state_q == ST_IDLE) && op_start && (kind != OPK_NONE);
        erasing = (state_q == ST_ZERO) || (state_q == ST_FILL);
        running = erasing || (state_q == ST_PWR) || (state_q == ST_PWAIT);
        sw_clr  = accept || ((state_q == ST_ZERO) && sw_last && !lim_hit);
    end

    flash_op_timer #(.TMR_W(TMR_W), .PROG_CYCLES(PROG_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .clr(accept), .inc(running),
        .limit(time_limit), .lim_hit(lim_hit), .min_hit(min_hit)
    );

    flash_op_sweep #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) sweep_i (
        .clk(clk), .rst_n(rst_n), .clr(sw_clr), .step(erasing),
        .whole(whole_q), .base(paddr_q), .addr(sw_addr), .last(sw_last)
    );

    flash_op_status status_i (
        .clk(clk), .rst_n(rst_n), .clr(accept), .busy(busy),
        .rd_strobe(rd_strobe), .tgt_msb(tgt_q[7]),
        .timed_out(state_q == ST_TMO), .arr_rdata(arr_rdata), .rd_data(rd_data)
    );

    // Next-state logic of the operation sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (accept) state_d = (kind == OPK_PROG) ? ST_PWR : ST_ZERO;
            ST_PWR:   state_d = ST_PWAIT;
            ST_PWAIT: begin
                if (min_hit && (arr_rdata == tgt_q)) state_d = ST_IDLE;
                else if (lim_hit)                    state_d = ST_TMO;
            end
            ST_ZERO: begin
                if (lim_hit)      state_d = ST_TMO;
                else if (sw_last) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (sw_last)      state_d = ST_IDLE;
                else if (lim_hit) state_d = ST_TMO;
            end
            ST_TMO:   if (reset_cmd) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State, completion pulse and latched operation fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            tgt_q   <= 8'hFF;
            paddr_q <= '0;
            whole_q <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= running && (state_d == ST_IDLE);
            if (accept) begin
                tgt_q   <= (kind == OPK_PROG) ? op_data : 8'hFF;
                paddr_q <= op_addr;
                whole_q <= (kind == OPK_CHIP);
            end
        end
    end

    // Array port ownership and write data.
    always_comb begin
        case (state_q)
            ST_PWR, ST_PWAIT: arr_addr = paddr_q;
            ST_ZERO, ST_FILL: arr_addr = sw_addr;
            default:          arr_addr = host_addr;
        endcase
        arr_we    = (state_q == ST_PWR) || erasing;
        if (state_q == ST_PWR)       arr_wdata = arr_rdata & tgt_q;
        else if (state_q == ST_ZERO) arr_wdata = 8'h00;
        else                         arr_wdata = 8'hFF;
        busy = (state_q != ST_IDLE);
        done = done_q;
    end
endmodule

// File: rtl/flash_op_sequencer_chk.sv
// Checker: port-level properties of the sequencer, attached by bind.
module flash_op_sequencer_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe,
    input logic              reset_cmd,
    input logic [7:0]        arr_rdata,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              arr_we,
    input logic [7:0]        arr_wdata,
    input logic [7:0]        rd_data,
    input logic              busy,
    input logic              done
);
    // Completion pulse ends a busy period (R4).
    assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // Writes happen only inside an operation (R3).
    assert_write_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // No write raises a cleared bit except the erase fill (R10).
    assert_bits_only_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && (arr_wdata != 8'hFF)) |-> ((arr_wdata & ~arr_rdata) == 8'h00));

    // Timeout persists until a reset command (R7, R8).
    assert_timeout_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_data[5] && !reset_cmd) |=> (busy && rd_data[5] && !done));

    // Toggle bit inverts after a busy read (R6).
    assert_toggle_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_strobe) |=> (!busy || (rd_data[6] != $past(rd_data[6]))));

    // Toggle and polling bits hold without a read (R5).
    assert_status_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_strobe) |=> (!busy || $stable(rd_data[7:6])));

    // Low status bits read as zero (R5).
    assert_status_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_data[4:0] == 5'b00000));

    // Idle reads pass the array byte (R11).
    assert_idle_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((rd_data == arr_rdata) && !arr_we && (arr_addr == arr_addr)));
endmodule

bind flash_op_sequencer flash_op_sequencer_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .reset_cmd(reset_cmd),
    .arr_rdata(arr_rdata), .arr_addr(arr_addr), .arr_we(arr_we),
    .arr_wdata(arr_wdata), .rd_data(rd_data), .busy(busy), .done(done)
);

// File: tb/flash_op_sequencer_tb_top.sv
module flash_op_sequencer_tb_top;
    localparam int AW    = 8;
    localparam int SW    = 2;
    localparam int TW    = 16;
    localparam int PROGC = 8;
    localparam int DEPTH = 1 << AW;
    localparam int SECT  = 1 << (AW - SW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 1'b0;
    logic [1:0]    op_kind = 2'd0;
    logic [AW-1:0] op_addr = '0;
    logic [7:0]    op_data = 8'h00;
    logic [TW-1:0] time_limit = 16'd40;
    logic          rd_strobe = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic          reset_cmd = 1'b0;
    logic [7:0]    arr_rdata;
    logic [AW-1:0] arr_addr;
    logic          arr_we;
    logic [7:0]    arr_wdata;
    logic [7:0]    rd_data;
    logic          busy, done;

    logic [7:0] mem     [DEPTH];
    logic [7:0] exp_mem [DEPTH];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 0;
    string cur_req = "R1";

    // reference model state
    int       m_st = 0;   // 0 idle,1 pwrite,2 pwait,3 zero,4 fill,5 timeout
    int       m_cnt = 0, m_idx = 0, m_base = 0, m_len = 0, m_addr = 0;
    bit [7:0] m_tgt = 8'hFF;
    bit       m_tog = 0, m_done = 0;

    always #4 clk = ~clk;

    flash_op_sequencer #(.ADDR_W(AW), .SECT_W(SW), .TMR_W(TW), .PROG_CYCLES(PROGC)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .time_limit(time_limit),
        .rd_strobe(rd_strobe), .host_addr(host_addr), .reset_cmd(reset_cmd),
        .arr_rdata(arr_rdata), .arr_addr(arr_addr), .arr_we(arr_we),
        .arr_wdata(arr_wdata), .rd_data(rd_data), .busy(busy), .done(done)
    );

    // external array
    assign arr_rdata = mem[arr_addr];
    always @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;

    // behavioural reference, advanced on each clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tog = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (rd_strobe && m_st != 0) m_tog = ~m_tog;
            case (m_st)
                0: if (op_start && op_kind != 2'd3) begin
                    m_tog = 0; m_cnt = 0; m_idx = 0;
                    if (op_kind == 2'd0) begin
                        m_st = 1; m_tgt = op_data; m_addr = int'(op_addr);
                    end else begin
                        m_st = 3; m_tgt = 8'hFF;
                        m_base = (op_kind == 2'd1) ? (int'(op_addr) / SECT) * SECT : 0;
                        m_len  = (op_kind == 2'd1) ? SECT : DEPTH;
                    end
                end
                1: begin
                    exp_mem[m_addr] = exp_mem[m_addr] & m_tgt;
                    m_st = 2; m_cnt = 1;
                end
                2: begin
                    if (m_cnt >= PROGC && exp_mem[m_addr] == m_tgt) begin m_st = 0; m_done = 1; end
                    else if (m_cnt >= int'(time_limit)) m_st = 5;
                    else m_cnt++;
                end
                3, 4: begin
                    exp_mem[m_base + m_idx] = (m_st == 3) ? 8'h00 : 8'hFF;
                    if (m_st == 4 && m_idx == m_len - 1) begin m_st = 0; m_done = 1; end
                    else if (m_cnt >= int'(time_limit)) m_st = 5;
                    else begin
                        if (m_idx == m_len - 1) begin m_idx = 0; m_st = 4; end
                        else m_idx++;
                        m_cnt++;
                    end
                end
                5: if (reset_cmd) m_st = 0;
                default: m_st = 0;
            endcase
        end
    end

    function automatic logic [7:0] exp_rd();
        if (m_st != 0) return {~m_tgt[7], m_tog, (m_st == 5), 5'b00000};
        return exp_mem[host_addr];
    endfunction

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            checks++;
            if (busy !== (m_st != 0)) begin
                fails++; $display("FAIL %s busy act=%0b exp=%0b t=%0t", cur_req, busy, (m_st != 0), $time);
            end
            checks++;
            if (done !== m_done) begin
                fails++; $display("FAIL %s done act=%0b exp=%0b t=%0t", cur_req, done, m_done, $time);
            end
            checks++;
            if (rd_data !== exp_rd()) begin
                fails++; $display("FAIL %s rd_data act=%02h exp=%02h t=%0t", cur_req, rd_data, exp_rd(), $time);
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++; $display("FAIL %s act=%02h exp=%02h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    task automatic start_op(logic [1:0] k, logic [AW-1:0] a, logic [7:0] d);
        op_kind = k; op_addr = a; op_data = d; op_start = 1'b1;
        step(1);
        op_start = 1'b0;
    endtask

    // wait until idle, issuing read strobes on alternate cycles
    task automatic run_busy(int maxc);
        for (int i = 0; i < maxc && m_st != 0 && m_st != 5; i++) begin
            rd_strobe = (i % 2 == 0);
            step(1);
        end
        rd_strobe = 1'b0;
    endtask

    task automatic read_range(int lo, int hi);
        for (int a = lo; a <= hi; a++) begin
            host_addr = AW'(a);
            #1; chk("R9", rd_data, exp_mem[a]);
            step(1);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !ended) begin
            fails++; $display("FAIL watchdog act=%0d exp=<100000", cyc);
            summary();
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 8'(i * 37 + 11); exp_mem[i] = 8'(i * 37 + 11);
        end
        for (int i = 16; i < 80; i += 16) begin mem[i] = 8'hFF; exp_mem[i] = 8'hFF; end
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        cur_req = "R1";
        chk("R1", {7'd0, busy}, 8'd0);
        chk("R1", {7'd0, done}, 8'd0);
        chk("R1", {7'd0, arr_we}, 8'd0);

        // R11 idle reads
        cur_req = "R11";
        for (int a = 0; a < 8; a++) begin
            host_addr = AW'(a * 29); #1;
            chk("R11", rd_data, exp_mem[a * 29]);
            step(1);
        end

        // R2 reserved code ignored
        cur_req = "R2";
        start_op(2'd3, 8'h10, 8'h00);
        chk("R2", {7'd0, busy}, 8'd0);

        // R3/R4/R5/R6 program FFh -> 5Ah, reset_cmd mid-run ignored (R8)
        cur_req = "R4";
        time_limit = 16'd40;
        start_op(2'd0, 8'h10, 8'h5A);
        chk("R5", rd_data, 8'h80);
        rd_strobe = 1'b1; step(1); rd_strobe = 1'b0;
        chk("R6", rd_data, 8'hC0);
        reset_cmd = 1'b1; start_op(2'd2, 8'h00, 8'h00); reset_cmd = 1'b0;
        chk("R8", {7'd0, busy}, 8'd1);
        run_busy(60);
        host_addr = 8'h10; #1;
        chk("R3", rd_data, 8'h5A);
        step(2);

        // R5 target with top bit 1
        cur_req = "R5";
        start_op(2'd0, 8'h40, 8'hC3);
        chk("R5", rd_data, 8'h00);
        run_busy(60);
        host_addr = 8'h40; #1;
        chk("R4", rd_data, 8'hC3);
        step(1);

        // R7 0-to-1 request: AND result 00h, then timeout
        cur_req = "R7";
        time_limit = 16'd20;
        start_op(2'd0, 8'h10, 8'hA5);
        run_busy(60);
        step(3);
        chk("R7", rd_data & 8'h20, 8'h20);
        chk("R7", {7'd0, busy}, 8'd1);
        start_op(2'd0, 8'h30, 8'h00);
        chk("R2", rd_data & 8'h20, 8'h20);
        cur_req = "R8";
        reset_cmd = 1'b1; step(1); reset_cmd = 1'b0;
        chk("R8", {7'd0, busy}, 8'd0);
        host_addr = 8'h10; #1;
        chk("R3", rd_data, 8'h00);
        step(1);

        // R9 sector erase of sector 1
        cur_req = "R9";
        time_limit = 16'd300;
        start_op(2'd1, 8'h47, 8'h00);
        chk("R5", rd_data, 8'h00);
        run_busy(400);
        step(1);
        read_range(SECT - 4, 2 * SECT + 3);

        // R7 chip erase cut off by its limit
        cur_req = "R7";
        time_limit = 16'd100;
        start_op(2'd2, 8'h00, 8'h00);
        run_busy(400);
        step(2);
        chk("R7", rd_data & 8'h20, 8'h20);
        reset_cmd = 1'b1; step(1); reset_cmd = 1'b0;
        cur_req = "R9";
        read_range(95, 104);

        // R9 full chip erase
        time_limit = 16'd1000;
        start_op(2'd2, 8'h00, 8'h00);
        run_busy(1200);
        step(1);
        read_range(0, 7);
        read_range(DEPTH - 8, DEPTH - 1);

        step(2);
        summary();
    end
endmodule